// File: doc/BRIEF.md
# Receive descriptor ring writer

This block is the receive-side descriptor engine of an Ethernet MAC. Software places a ring of two-word descriptors in memory and loads the ring's base address. For each incoming frame, the block reads the first word of the descriptor at its current ring position. If that descriptor is free, the block copies the frame payload into the buffer the descriptor names. It then writes a status word carrying the length and frame-boundary flags. Last, it marks the descriptor as owned by software and steps to the next descriptor, or back to the base when the descriptor carries the ring-end flag.

Frames arrive as a byte stream with a last-byte marker, and the stream still includes the four trailing FCS bytes. The block removes those bytes with a short delay line. Memory is reached through a single request/acknowledge port. Each payload byte is stored with its own single-lane write. A frame that finds its descriptor still owned by software is drained from the stream without any memory write, and a one-cycle resource-error pulse is raised.

Top module: `rx_desc_writer`

## Requirements
- R1: After reset the block issues no memory request, holds `rx_ready_o` low and holds `rsrc_err_o` low.
- R2: When a frame's first byte is offered, the block reads descriptor word 0 at the current ring position. Descriptors are 8 bytes apart, and the buffer address is word 0 with bits 1:0 cleared.
- R3: Payload byte k is written at byte address buffer+k. The write goes to the word-aligned address, with `mem_be_o` = 1 << (address bits 1:0) and the byte repeated on all four lanes. Bytes are written in arrival order, and `rx_ready_o` stays low while any memory request is open.
- R4: The last four bytes of every frame are never written and never counted. A frame of four bytes or fewer produces no data write and a length of 0.
- R5: The status word is written at descriptor address + 4. Bits 13:0 hold the stored length, bits 14 (start) and 15 (end) are both 1, and all other bits are 0.
- R6: The status write comes before the ownership write. The ownership write stores the word 0 value that was read, with bit 0 set, so the buffer address and bit 1 are kept.
- R7: After the ownership write, the ring position moves forward by 8 bytes. If bit 1 of the word 0 that was read was set, it returns to the base instead.
- R8: If bit 0 of the word 0 that was read is 1, the frame is consumed with no memory write. `rsrc_err_o` pulses for one cycle, and the ring position does not change.
- R9: Loading a new base through `qbase_wr_i` sets the ring position to that base (bits 2:0 cleared). The next frame uses the new ring.
- R10: Payload bytes beyond BUF_BYTES (default 1536) are not written, and the stored length saturates at BUF_BYTES.
- R11: A memory request keeps its address, data, enables and direction unchanged until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| qbase_wr_i | input | 1 | Load a new ring base address |
| qbase_i | input | AW | Ring base address |
| rx_valid_i | input | 1 | Stream byte valid |
| rx_data_i | input | 8 | Stream byte |
| rx_last_i | input | 1 | Marks the last byte of a frame (FCS included) |
| rx_ready_o | output | 1 | Block accepts the stream byte |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completed; read data valid |
| mem_rdata_i | input | 32 | Read data |
| rsrc_err_o | output | 1 | One-cycle pulse when a frame is dropped because its descriptor is owned |

## Verification
The hardest case to reach is a frame arriving when the ring has wrapped back onto a descriptor that software has not yet freed. To get there, the stimulus fills every descriptor of a four-entry ring, so the wrap flag sends the position back onto the still-owned first entry. The next frame must then be dropped with no memory writes. After that, the bench frees the descriptor in memory and sends another frame. This shows that the ring position was not moved by the drop. The same situation is created again on a second, two-entry ring, loaded mid-run, after a frame longer than the buffer, so that both truncation and the base reload lead into a drop.

// File: rtl/rdw_pkg.sv
package rdw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DROP, S_RECV, S_WBYTE, S_STAT, S_OWN
  } rdw_state_e;

  localparam int unsigned USED_BIT   = 0;
  localparam int unsigned WRAP_BIT   = 1;
  localparam int unsigned SOF_BIT    = 14;
  localparam int unsigned EOF_BIT    = 15;
  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned STAT_OFS   = 4;
endpackage

// File: rtl/rdw_fcs_strip.sv
module rdw_fcs_strip #(
  parameter int unsigned TAIL = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       push_i,
  input  logic [7:0] data_i,
  output logic       out_valid_o,
  output logic [7:0] out_data_o
);
  localparam int unsigned FW = $clog2(TAIL + 1);

  logic [7:0]    pipe_q [TAIL];
  logic [FW-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      for (int i = 0; i < TAIL; i++) pipe_q[i] <= '0;
    end else if (clear_i) begin
      fill_q <= '0;
    end else if (push_i) begin
      pipe_q[0] <= data_i;
      for (int i = 1; i < TAIL; i++) pipe_q[i] <= pipe_q[i-1];
      if (fill_q != FW'(TAIL)) fill_q <= fill_q + FW'(1);
    end
  end

  // a byte leaves only once TAIL newer bytes stand behind it
  assign out_valid_o = push_i && (fill_q == FW'(TAIL));
  assign out_data_o  = pipe_q[TAIL-1];

  a_r4_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !out_valid_o);
endmodule

// File: rtl/rdw_ring_ptr.sv
module rdw_ring_ptr #(
  parameter int unsigned AW         = 32,
  parameter int unsigned DESC_BYTES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_wr_i,
  input  logic [AW-1:0] base_i,
  input  logic          start_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(DESC_BYTES - 1);

  logic [AW-1:0] base_q, ptr_q;
  logic          hold_q;  // base reloaded since frame start: skip advance

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ptr_q  <= '0;
      hold_q <= 1'b0;
    end else if (base_wr_i) begin
      base_q <= base_i & ALIGN_MASK;
      ptr_q  <= base_i & ALIGN_MASK;
      hold_q <= 1'b1;
    end else begin
      if (start_i) hold_q <= 1'b0;
      if (adv_i && !hold_q) ptr_q <= wrap_i ? base_q : ptr_q + AW'(DESC_BYTES);
    end
  end

  assign ptr_o = ptr_q;

  a_r9_base_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_wr_i |=> ptr_o == ($past(base_i) & ALIGN_MASK));
  a_r7_wrap_to_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && wrap_i && !hold_q && !base_wr_i |=> ptr_o == $past(base_q));
endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
  import rdw_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned BUF_BYTES = 1536,
  parameter int unsigned LEN_W     = 14,
  parameter int unsigned FCS_BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          qbase_wr_i,
  input  logic [AW-1:0] qbase_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_last_i,
  output logic          rx_ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [3:0]    mem_be_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          rsrc_err_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(BUF_BYTES);

  rdw_state_e       state_q;
  logic [AW-1:0]    desc_q, wa_q, ptr;
  logic [31:0]      w0_q;
  logic [LEN_W-1:0] len_q;
  logic [7:0]       wb_q;
  logic             last_q, err_q, stat_done_q;

  logic accept, fetch_ack, start, adv, sv_valid, room;
  logic [7:0]    sv_data;
  logic [AW-1:0] buf_base;

  assign rx_ready_o = (state_q == S_RECV) || (state_q == S_DROP);
  assign accept     = rx_valid_i && rx_ready_o;
  assign fetch_ack  = (state_q == S_FETCH) && mem_ack_i;
  assign start      = (state_q == S_IDLE) && rx_valid_i;
  assign adv        = (state_q == S_OWN) && mem_ack_i;
  assign room       = len_q < LEN_MAX;
  assign buf_base   = AW'({w0_q[31:2], 2'b00});

  rdw_ring_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) i_ptr (
    .clk_i, .rst_ni,
    .base_wr_i (qbase_wr_i),
    .base_i    (qbase_i),
    .start_i   (start),
    .adv_i     (adv),
    .wrap_i    (w0_q[WRAP_BIT]),
    .ptr_o     (ptr)
  );

  rdw_fcs_strip #(.TAIL(FCS_BYTES)) i_strip (
    .clk_i, .rst_ni,
    .clear_i     (fetch_ack),
    .push_i      (accept && state_q == S_RECV),
    .data_i      (rx_data_i),
    .out_valid_o (sv_valid),
    .out_data_o  (sv_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      desc_q      <= '0;
      w0_q        <= '0;
      len_q       <= '0;
      wa_q        <= '0;
      wb_q        <= '0;
      last_q      <= 1'b0;
      err_q       <= 1'b0;
      stat_done_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (rx_valid_i) begin
          desc_q      <= ptr;
          stat_done_q <= 1'b0;
          state_q     <= S_FETCH;
        end
        S_FETCH: if (mem_ack_i) begin
          w0_q  <= mem_rdata_i;
          len_q <= '0;
          if (mem_rdata_i[USED_BIT]) begin
            err_q   <= 1'b1;
            state_q <= S_DROP;
          end else begin
            state_q <= S_RECV;
          end
        end
        S_DROP: if (accept && rx_last_i) state_q <= S_IDLE;
        S_RECV: if (accept) begin
          last_q <= rx_last_i;
          if (sv_valid && room) begin
            wa_q    <= buf_base + AW'(len_q);
            wb_q    <= sv_data;
            len_q   <= len_q + LEN_W'(1);
            state_q <= S_WBYTE;
          end else if (rx_last_i) begin
            state_q <= S_STAT;
          end
        end
        S_WBYTE: if (mem_ack_i) state_q <= last_q ? S_STAT : S_RECV;
        S_STAT: if (mem_ack_i) begin
          stat_done_q <= 1'b1;
          state_q     <= S_OWN;
        end
        S_OWN: if (mem_ack_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = 4'hF;
    mem_wdata_o = '0;
    unique case (state_q)
      S_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_q;
      end
      S_WBYTE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {wa_q[AW-1:2], 2'b00};
        mem_be_o    = 4'b0001 << wa_q[1:0];
        mem_wdata_o = {4{wb_q}};
      end
      S_STAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_q + AW'(STAT_OFS);
        mem_wdata_o[LEN_W-1:0] = len_q;
        mem_wdata_o[SOF_BIT]   = 1'b1;
        mem_wdata_o[EOF_BIT]   = 1'b1;
      end
      S_OWN: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_q;
        mem_wdata_o = w0_q | 32'h1;
      end
      default: ;
    endcase
  end

  assign rsrc_err_o = err_q;

  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                              && $stable(mem_be_o) && $stable(mem_wdata_o));
  a_r3_stall_on_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> !mem_req_o);
  a_r6_status_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_addr_o == desc_q |-> stat_done_q);
  a_r8_err_after_used: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsrc_err_o |-> $past(mem_ack_i && mem_rdata_i[USED_BIT] && !mem_we_o));
  a_r10_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= LEN_MAX);
endmodule

// File: tb/test_rx_desc_writer.sv
module test_rx_desc_writer;
  localparam int BUFB = 1536;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qbase_wr = 1'b0;
  logic [31:0] qbase = '0;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, mem_req, mem_we, rsrc_err;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, errors = 0, err_seen = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_addr[$], exp_data[$];
  logic [3:0]  exp_be[$];
  string       exp_tag[$];

  always #5 clk = ~clk;

  rx_desc_writer i_rx_desc_writer (
    .clk_i(clk), .rst_ni(rst_n), .qbase_wr_i(qbase_wr), .qbase_i(qbase),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last), .rx_ready_o(rx_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rsrc_err_o(rsrc_err)
  );

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst_n && mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        logic [31:0] w;
        w = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        for (int b = 0; b < 4; b++) if (mem_be[b]) w[b*8 +: 8] = mem_wdata[b*8 +: 8];
        mem[mem_addr] = w;
      end else begin
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard compare, stall rule, handshake stability, error pulses
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsrc_err) err_seen++;
      if (rx_ready && mem_req) check("R3 ready during mem request", 32'(rx_ready && mem_req), 32'h0);
      if (pend && mem_req && mem_addr !== pend_addr) check("R11 address held", mem_addr, pend_addr);
      pend      <= mem_req && !mem_ack;
      pend_addr <= mem_addr;
      if (mem_req && mem_we && mem_ack) begin
        if (exp_addr.size() == 0) begin
          check("R8 unexpected write", mem_addr, 32'hFFFF_FFFF);
        end else begin
          logic [31:0] ea, ed, m;
          logic [3:0]  eb;
          string       t;
          ea = exp_addr.pop_front(); ed = exp_data.pop_front();
          eb = exp_be.pop_front();   t  = exp_tag.pop_front();
          m = {{8{eb[3]}}, {8{eb[2]}}, {8{eb[1]}}, {8{eb[0]}}};
          check({t, " addr"}, mem_addr, ea);
          check({t, " be"}, 32'(mem_be), 32'(eb));
          check({t, " data"}, mem_wdata & m, ed & m);
        end
      end
    end
  end

  task automatic push_exp(logic [31:0] a, logic [3:0] be, logic [31:0] d, string t);
    exp_addr.push_back(a); exp_be.push_back(be); exp_data.push_back(d); exp_tag.push_back(t);
  endtask

  task automatic load_base(logic [31:0] b);
    @(negedge clk); qbase_wr = 1'b1; qbase = b;
    @(negedge clk); qbase_wr = 1'b0;
  endtask

  task automatic send_frame(int n, int seed, logic [31:0] desc, bit drop);
    logic [31:0] w0, bufa, a;
    int k, w;
    w0   = mem.exists(desc) ? mem[desc] : 32'h0;
    bufa = {w0[31:2], 2'b00};
    k    = (n > 4) ? n - 4 : 0;
    w    = (k > BUFB) ? BUFB : k;
    if (!drop) begin
      for (int i = 0; i < w; i++) begin
        a = bufa + 32'(i);
        push_exp({a[31:2], 2'b00}, 4'b0001 << a[1:0], {4{8'((seed + i) & 255)}}, "R3 data");
      end
      push_exp(desc + 4, 4'hF, 32'(w) | 32'h0000_C000, "R5 status");
      push_exp(desc, 4'hF, w0 | 32'h1, "R6 ownership");
    end
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = 8'((seed + i) & 255); rx_last = (i == n - 1);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0;
    for (int t = 0; t < 50 && exp_addr.size() != 0; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R2 frame writes completed", 32'(exp_addr.size()), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready after reset", 32'(rx_ready), 32'h0);
    check("R1 request after reset", 32'(mem_req), 32'h0);
    check("R1 error after reset", 32'(rsrc_err), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle without stream", 32'(mem_req), 32'h0);

    // ring A: four descriptors, last one wraps
    for (int i = 0; i < 4; i++) begin
      mem[32'h1000 + 32'(8*i)]     = 32'h4000 + 32'(32'h800 * i) | ((i == 3) ? 32'h2 : 32'h0);
      mem[32'h1000 + 32'(8*i) + 4] = 32'h0;
    end
    load_base(32'h1000);

    send_frame(10, 16, 32'h1000, 1'b0);           // R2 R3 R5
    check("R5 status in memory", mem[32'h1004], 32'h0000_C006);
    check("R6 word0 in memory", mem[32'h1000], 32'h0000_4001);
    send_frame(4, 80, 32'h1008, 1'b0);            // R4 exactly FCS
    check("R4 four-byte frame length", mem[32'h100C], 32'h0000_C000);
    send_frame(2, 90, 32'h1010, 1'b0);            // R4 shorter than FCS
    check("R4 two-byte frame length", mem[32'h1014], 32'h0000_C000);
    send_frame(7, 200, 32'h1018, 1'b0);           // R7 wrap descriptor
    check("R7 wrap flag kept", mem[32'h1018], 32'h0000_5803);

    send_frame(9, 33, 32'h1000, 1'b1);            // R8 wrapped onto owned entry
    check("R8 drop error pulse", 32'(err_seen), 32'h1);
    check("R8 owned descriptor untouched", mem[32'h1004], 32'h0000_C006);

    mem[32'h1000] = 32'h4000;                     // software frees entry 0
    send_frame(6, 7, 32'h1000, 1'b0);             // R7 R8 ring position kept
    check("R7 position after wrap", mem[32'h1004], 32'h0000_C002);

    // ring B: two descriptors
    mem[32'h2000] = 32'h8000;     mem[32'h2004] = 32'h0;
    mem[32'h2008] = 32'h8802;     mem[32'h200C] = 32'h0;
    load_base(32'h2003);                          // R9 low bits dropped
    send_frame(5, 100, 32'h2000, 1'b0);
    check("R9 new ring used", mem[32'h2000], 32'h0000_8001);
    send_frame(BUFB + 7, 3, 32'h2008, 1'b0);      // R10 oversize
    check("R10 length saturates", mem[32'h200C], 32'h0000_C000 | 32'(BUFB));
    check("R10 byte past buffer untouched", mem.exists(32'h8E00) ? mem[32'h8E00] : 32'h0, 32'h0);
    send_frame(8, 55, 32'h2000, 1'b1);            // R7 wrap to new base, R8 drop
    check("R8 second drop pulse", 32'(err_seen), 32'h2);
    check("R3 scoreboard drained", 32'(exp_addr.size()), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule